// File: doc/BRIEF.md
# Staged Tile Reset Sequencer

This block brings a processor tile out of reset in a fixed order once board configuration has finished. When the configuration-done input goes high, it first releases the reset for the serial configuration link. It then counts a short interval and releases power-on reset. After that it waits until the combined PLL lock indication is high, counts a longer interval, and releases system reset. Copies of both resets are driven for the warm and cold reset pins of the tile.

An external active-low reset request pulls system reset low at once. Power-on reset stays released during the request. When the request is removed and lock is present, system reset is released again after the long interval. If lock is lost, system reset is asserted again. If configuration-done falls, every reset output drops at once and the whole sequence starts over.

The two intervals are given in microseconds. The block multiplies each one by the clock frequency parameter (in MHz) to get a cycle count. The lock and request inputs pass through two-flop synchronizers before the sequencer acts on them, and so does the configuration-done input.

Top module: `tile_reset_stager`

## Requirements
- R1: While `rst_n` is low, all five reset outputs are low.
- R2: `link_rst_n` goes high 3 clock edges after `cfg_done` rises. It is low in any cycle in which `cfg_done` is low.
- R3: `por_rst_n` goes high POR_CYC+3 edges after `cfg_done` rises, where POR_CYC = CLK_MHZ*POR_DELAY_US.
- R4: `sys_rst_n` is never high while `por_rst_n` is low. With lock already present, it goes high POR_CYC+SYS_CYC+4 edges after `cfg_done` rises, where SYS_CYC = CLK_MHZ*SYS_DELAY_US. While lock is absent it stays low indefinitely. Once lock appears, it goes high SYS_CYC+3 edges later.
- R5: When `pll_locked` falls while system reset is released, `sys_rst_n` goes low 3 edges later and `por_rst_n` stays high.
- R6: While `rst_req_n` is low, `sys_rst_n` is low in the same cycle, with no clock edge in between. `por_rst_n` is unaffected.
- R7: When `rst_req_n` returns high with lock present, `sys_rst_n` goes high SYS_CYC+3 edges later.
- R8: `warm_rst_n` always equals `sys_rst_n`, and `cold_rst_n` always equals `por_rst_n`.
- R9: When `cfg_done` goes low, all outputs are low in the same cycle. When it rises again, the full sequence of R2 to R4 repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| cfg_done | input | 1 | High once all board configuration has completed |
| pll_locked | input | 1 | Combined PLL lock indication, asynchronous |
| rst_req_n | input | 1 | External reset request, active low, asynchronous |
| por_rst_n | output | 1 | Power-on reset to the tile, active low |
| sys_rst_n | output | 1 | System reset to the tile, active low |
| warm_rst_n | output | 1 | Warm reset copy of system reset |
| cold_rst_n | output | 1 | Cold reset copy of power-on reset |
| link_rst_n | output | 1 | Reset of the serial configuration link, active low |

## Verification
There are two kinds of timing. Releases go through the synchronizer pair and the stage register, so each one is due a fixed number of edges after its cause. The link reset is released 3 edges after `cfg_done` rises. Power-on reset is released after POR_CYC+3 edges, system reset after the further SYS_CYC+1 edges, and a return from a request or a lock gap takes SYS_CYC+3 edges. Assertions caused by a request or by a fall of `cfg_done` are combinational and due in the same cycle. Lock loss takes 3 edges.

The bench drives inputs on the falling edge. It samples 1 to 2 ns later and counts whole clock periods from the driving edge. It also compares every output against a behavioural model on every clock.

// File: rtl/rst_stage_pkg.sv
package rst_stage_pkg;

  typedef enum logic [2:0] {
    STG_IDLE      = 3'd0,
    STG_POR_HOLD  = 3'd1,
    STG_LOCK_WAIT = 3'd2,
    STG_SYS_HOLD  = 3'd3,
    STG_RUN       = 3'd4,
    STG_REQ_HOLD  = 3'd5
  } stage_e;

  function automatic int unsigned cycles_of(input int unsigned mhz,
                                            input int unsigned usec);
    return mhz * usec;
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic meta_q;
      logic sync_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= RST_VAL[gi];
          sync_q <= RST_VAL[gi];
        end else begin
          meta_q <= d[gi];
          sync_q <= meta_q;
        end
      end

      assign q[gi] = sync_q;
    end
  endgenerate

endmodule

// File: rtl/stage_timer.sv
module stage_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] term,
  output logic          hit
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit = en && (cnt_q == term);

endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import rst_stage_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_s,
  input  logic lock_s,
  input  logic req_s,
  input  logic hit,
  output logic cnt_clr,
  output logic cnt_en,
  output logic use_sys,
  output logic link_q,
  output logic por_q,
  output logic sys_q
);

  stage_e cur_q;
  stage_e nxt;
  logic   link_d;
  logic   por_d;
  logic   sys_d;

  always_comb begin
    nxt     = cur_q;
    cnt_en  = 1'b0;
    use_sys = 1'b0;
    unique case (cur_q)
      STG_IDLE: begin
        if (cfg_s) nxt = STG_POR_HOLD;
      end
      STG_POR_HOLD: begin
        cnt_en = 1'b1;
        if (hit) nxt = STG_LOCK_WAIT;
      end
      STG_LOCK_WAIT: begin
        if (lock_s && !req_s) nxt = STG_SYS_HOLD;
      end
      STG_SYS_HOLD: begin
        cnt_en  = 1'b1;
        use_sys = 1'b1;
        if (req_s)        nxt = STG_REQ_HOLD;
        else if (!lock_s) nxt = STG_LOCK_WAIT;
        else if (hit)     nxt = STG_RUN;
      end
      STG_RUN: begin
        if (req_s)        nxt = STG_REQ_HOLD;
        else if (!lock_s) nxt = STG_LOCK_WAIT;
      end
      STG_REQ_HOLD: begin
        if (!req_s) nxt = lock_s ? STG_SYS_HOLD : STG_LOCK_WAIT;
      end
      default: nxt = STG_IDLE;
    endcase
    if (!cfg_s) nxt = STG_IDLE;
    cnt_clr = (nxt != cur_q);
  end

  always_comb begin
    link_d = (nxt != STG_IDLE);
    por_d  = (nxt != STG_IDLE) && (nxt != STG_POR_HOLD);
    sys_d  = (nxt == STG_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= STG_IDLE;
      link_q <= 1'b0;
      por_q  <= 1'b0;
      sys_q  <= 1'b0;
    end else begin
      cur_q  <= nxt;
      link_q <= link_d;
      por_q  <= por_d;
      sys_q  <= sys_d;
    end
  end

endmodule

// File: rtl/tile_reset_stager.sv
module tile_reset_stager
  import rst_stage_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned POR_DELAY_US = 7,
  parameter int unsigned SYS_DELAY_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic pll_locked,
  input  logic rst_req_n,
  output logic por_rst_n,
  output logic sys_rst_n,
  output logic warm_rst_n,
  output logic cold_rst_n,
  output logic link_rst_n
);

  localparam int unsigned POR_CYC = cycles_of(CLK_MHZ, POR_DELAY_US);
  localparam int unsigned SYS_CYC = cycles_of(CLK_MHZ, SYS_DELAY_US);
  localparam int unsigned MAX_CYC = (POR_CYC > SYS_CYC) ? POR_CYC : SYS_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] POR_TERM = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] SYS_TERM = CW'(SYS_CYC - 1);

  logic [2:0]    raw_v;
  logic [2:0]    syn_v;
  logic          cnt_clr;
  logic          cnt_en;
  logic          use_sys;
  logic          hit;
  logic [CW-1:0] term;
  logic          link_q;
  logic          por_q;
  logic          sys_q;

  assign raw_v = {cfg_done, pll_locked, ~rst_req_n};

  bit_sync #(.W(3), .RST_VAL(3'b000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_v),
    .q     (syn_v)
  );

  assign term = use_sys ? SYS_TERM : POR_TERM;

  stage_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .term  (term),
    .hit   (hit)
  );

  stage_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_s   (syn_v[2]),
    .lock_s  (syn_v[1]),
    .req_s   (syn_v[0]),
    .hit     (hit),
    .cnt_clr (cnt_clr),
    .cnt_en  (cnt_en),
    .use_sys (use_sys),
    .link_q  (link_q),
    .por_q   (por_q),
    .sys_q   (sys_q)
  );

  // assertion paths are combinational, releases are registered
  assign link_rst_n = link_q & cfg_done;
  assign por_rst_n  = por_q & cfg_done;
  assign sys_rst_n  = sys_q & cfg_done & rst_req_n;
  assign warm_rst_n = sys_rst_n;
  assign cold_rst_n = por_rst_n;

endmodule

// File: rtl/tile_reset_stager_chk.sv
module tile_reset_stager_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_done,
  input logic rst_req_n,
  input logic por_rst_n,
  input logic sys_rst_n,
  input logic link_rst_n
);

  assert_sys_needs_por_R4: assert property (
    @(posedge clk) disable iff (!rst_n) sys_rst_n |-> por_rst_n);

  assert_req_holds_sys_R6: assert property (
    @(posedge clk) disable iff (!rst_n) !rst_req_n |-> !sys_rst_n);

  assert_cfg_drop_clears_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      !cfg_done |-> (!por_rst_n && !link_rst_n && !sys_rst_n));

  assert_link_before_por_R2: assert property (
    @(posedge clk) disable iff (!rst_n) por_rst_n |-> link_rst_n);

  assert_por_rise_after_link_R3: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(por_rst_n) |-> $past(link_rst_n));

endmodule

bind tile_reset_stager tile_reset_stager_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_done   (cfg_done),
  .rst_req_n  (rst_req_n),
  .por_rst_n  (por_rst_n),
  .sys_rst_n  (sys_rst_n),
  .link_rst_n (link_rst_n)
);

// File: tb/sim_tile_reset_stager.sv
`timescale 1ns/1ps
module sim_tile_reset_stager;

  localparam int MHZ  = 2;
  localparam int PUS  = 7;
  localparam int SUS  = 20;
  localparam int PCYC = MHZ * PUS;
  localparam int SCYC = MHZ * SUS;

  logic clk = 1'b0;
  logic rst_n, cfg_done, pll_locked, rst_req_n;
  logic por_rst_n, sys_rst_n, warm_rst_n, cold_rst_n, link_rst_n;

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  tile_reset_stager #(.CLK_MHZ(MHZ), .POR_DELAY_US(PUS), .SYS_DELAY_US(SUS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .pll_locked(pll_locked),
    .rst_req_n(rst_req_n), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .warm_rst_n(warm_rst_n), .cold_rst_n(cold_rst_n), .link_rst_n(link_rst_n));

  // behavioural reference model
  bit s1c, s2c, s1l, s2l, s1r, s2r;
  bit m_link, m_por, m_sys, armed;
  int por_wait, sys_wait;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1c, s2c, s1l, s2l, s1r, s2r} = '0;
      m_link = 0; m_por = 0; m_sys = 0; armed = 0;
      por_wait = 0; sys_wait = 0;
    end else begin
      if (!s2c) begin
        m_link = 0; m_por = 0; m_sys = 0; armed = 0;
      end else if (!m_link) begin
        m_link = 1; por_wait = PCYC;
      end else if (!m_por) begin
        por_wait--;
        if (por_wait == 0) m_por = 1;
      end else if (s2r || !s2l) begin
        m_sys = 0; armed = 0;
      end else if (!m_sys) begin
        if (!armed) begin
          armed = 1; sys_wait = SCYC;
        end else begin
          sys_wait--;
          if (sys_wait == 0) m_sys = 1;
        end
      end
      s2c = s1c; s1c = cfg_done;
      s2l = s1l; s1l = pll_locked;
      s2r = s1r; s1r = ~rst_req_n;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done_flag) begin
      bit e_por, e_sys, e_link;
      e_link = rst_n && m_link && cfg_done;
      e_por  = rst_n && m_por && cfg_done;
      e_sys  = rst_n && m_sys && cfg_done && rst_req_n;
      check("R2 link model", link_rst_n, e_link);
      check("R3 por model", por_rst_n, e_por);
      check("R4 sys model", sys_rst_n, e_sys);
      check("R8 warm copy", warm_rst_n, e_sys);
      check("R8 cold copy", cold_rst_n, e_por);
    end
  end

  function automatic logic out_of(input int sel);
    case (sel)
      0: return link_rst_n;
      1: return por_rst_n;
      default: return sys_rst_n;
    endcase
  endfunction

  task automatic edges_until(input int sel, input logic lvl, output int k);
    k = 0;
    do begin
      @(negedge clk); #1; k++;
    end while (out_of(sel) !== lvl && k < 5000);
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int k;
    rst_n = 0; cfg_done = 0; pll_locked = 0; rst_req_n = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset por", por_rst_n, 0);
    check("R1 reset sys", sys_rst_n, 0);
    check("R1 reset link", link_rst_n, 0);
    check("R1 reset warm/cold", warm_rst_n | cold_rst_n, 0);
    @(negedge clk); rst_n = 1;
    pll_locked = 1;
    repeat (4) @(negedge clk);
    cfg_done = 1;
    edges_until(0, 1, k); check("R2 link release edges", k, 3);
    begin int j; edges_until(1, 1, j); check("R3 por release edges", k + j, PCYC + 3); k += j; end
    begin int j; edges_until(2, 1, j); check("R4 sys release edges", k + j, PCYC + SCYC + 4); end
    repeat (5) @(negedge clk);
    // R6 request
    rst_req_n = 0; #1;
    check("R6 sys low at once", sys_rst_n, 0);
    repeat (10) @(negedge clk); #1;
    check("R6 por kept", por_rst_n, 1);
    rst_req_n = 1;
    edges_until(2, 1, k); check("R7 sys after request", k, SCYC + 3);
    repeat (5) @(negedge clk);
    // R5 lock loss
    pll_locked = 0;
    edges_until(2, 0, k); check("R5 sys drop on lock loss", k, 3);
    check("R5 por kept", por_rst_n, 1);
    repeat (20) @(negedge clk);
    pll_locked = 1;
    edges_until(2, 1, k); check("R4 sys after lock", k, SCYC + 3);
    repeat (5) @(negedge clk);
    // R9 cfg drop
    cfg_done = 0; pll_locked = 0; #1;
    check("R9 por cleared", por_rst_n, 0);
    check("R9 sys cleared", sys_rst_n, 0);
    check("R9 link cleared", link_rst_n, 0);
    repeat (6) @(negedge clk);
    cfg_done = 1;
    edges_until(1, 1, k); check("R9 por restart edges", k, PCYC + 3);
    repeat (60) @(negedge clk); #1;
    check("R4 sys held without lock", sys_rst_n, 0);
    pll_locked = 1;
    edges_until(2, 1, k); check("R4 sys once locked", k, SCYC + 3);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule